// File: doc/BRIEF.md
# Compressed Branch Trace Address Serializer

This block takes branch-destination addresses from a processor core and sends them off-chip over a narrow trace port. The port has a 4-bit data bus, a sync strobe and a trace clock that runs at half the core clock. Each address is preceded by one header nibble that carries a 2-bit size code. Only the low-order nibbles that differ from the last address sent in full are transmitted, so short jumps cost 1, 2 or 4 data nibbles instead of 8.

The core offers one address at a time on a valid/ready handshake. An accepted address is held inside the block until its last nibble has left. While no packet is in flight, the port drives a fixed idle pattern. Once the last nibble of a packet is done, the completed address becomes the reference for the next comparison.

Top module: `branch_trace_serializer`

## Requirements
- R1: `trc_clk` is low in the first cycle after reset and toggles on every core clock edge. `trc_sync` and `trc_data` change only on the edge where `trc_clk` goes from 1 to 0, so each trace symbol lasts two core cycles.
- R2: After reset, and whenever no packet is in flight, `trc_sync` is 1 and `trc_data` is 4'b0011.
- R3: The first symbol of a packet is the header: `trc_sync`=1, `trc_data[3:2]`=2'b10, and `trc_data[1:0]` holds the size code. The next symbol is already an address nibble.
- R4: The size code is chosen by testing the smallest packet first. Code 00 applies when address bits 31:4 equal the reference. Code 01 applies when bits 31:8 equal it. Code 10 applies when bits 31:16 equal it. Code 11 applies otherwise.
- R5: After the header come exactly 1, 2, 4 or 8 address nibbles for codes 00, 01, 10 or 11, each with `trc_sync`=0.
- R6: Address nibbles go out least significant first: bits 3:0, then 7:4, then 11:8, and so on.
- R7: The reference is the full address of the most recently completed packet. No reference is valid after reset, so the first packet after reset uses code 11 whatever its address.
- R8: `br_ready` is 1 only in the second core cycle of a trace symbol, and only while the port is idle or showing the final nibble of a packet. A branch offered at any other time is held off and transmitted later, never lost.
- R9: The symbol after a packet's last nibble is either the idle pattern or, when a branch was accepted, the next header. A back-to-back header is compared against the address that has just completed.
- R10: Asserting the synchronous reset in the middle of a packet abandons it, returns the port to idle at the next edge and invalidates the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Core offers a branch destination |
| br_addr | input | 32 | Branch destination address |
| br_ready | output | 1 | Block takes `br_addr` on this edge when `br_valid` is 1 |
| trc_clk | output | 1 | Trace clock, half the core rate |
| trc_sync | output | 1 | High for idle and header symbols, low for address nibbles |
| trc_data | output | 4 | Trace data nibble |

## Verification
Two events can fall on the same trace edge: the last nibble of one packet finishes, which loads the reference register, and the next branch is accepted, which runs the length encoder. The encoder must use the address that is finishing, not the stale register contents. The bench provokes this by holding a new branch valid while a packet is still going out, and by sending nearby addresses with zero gap. It then checks that the header follows the last nibble with no idle symbol in between, and that the header's size code is computed against the address that has just completed.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int unsigned TRC_NIB_W = 4;
    localparam int unsigned TRC_NIBS  = 8;
    localparam int unsigned TRC_IDX_W = $clog2(TRC_NIBS);

    localparam logic [TRC_NIB_W-1:0] IDLE_PAT = 4'b0011;
    localparam logic [1:0]           HDR_TAG  = 2'b10;

    typedef logic [1:0] size_code_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } tx_state_t;

    typedef struct packed {
        logic [1:0] tag;
        size_code_t code;
    } hdr_t;

    // Index of the last nibble for a size code: 0, 1, 3 or nibs-1.
    function automatic int unsigned last_index(size_code_t c, int unsigned nibs);
        int unsigned r;
        case (c)
            2'b00:   r = 0;
            2'b01:   r = 1;
            2'b10:   r = 3;
            default: r = nibs - 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bts_clkdiv.sv
module bts_clkdiv (
    input  logic clk,
    input  logic rst,
    output logic phase,
    output logic tick
);
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    // The port updates on the edge where phase returns to 0.
    assign tick = phase;
endmodule

// File: rtl/bts_len_enc.sv
module bts_len_enc
    import bts_pkg::*;
#(
    parameter int unsigned NIB_W  = TRC_NIB_W,
    parameter int unsigned ADDR_W = TRC_NIB_W * TRC_NIBS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic              ref_ok,
    output size_code_t        code
);
    localparam int unsigned NUM_SHORT = 3;

    logic [NUM_SHORT-1:0] match;

    for (genvar g = 0; g < NUM_SHORT; g++) begin : g_cmp
        localparam int unsigned LO = NIB_W << g;
        assign match[g] = (addr[ADDR_W-1:LO] == ref_addr[ADDR_W-1:LO]);
    end

    always_comb begin
        if (!ref_ok)        code = 2'b11;
        else if (match[0])  code = 2'b00;
        else if (match[1])  code = 2'b01;
        else if (match[2])  code = 2'b10;
        else                code = 2'b11;
    end
endmodule

// File: rtl/bts_ref_reg.sv
module bts_ref_reg #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] ref_q,
    output logic              ref_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            ref_ok <= 1'b0;
        end else if (load) begin
            ref_q  <= din;
            ref_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/branch_trace_serializer.sv
module branch_trace_serializer
    import bts_pkg::*;
#(
    parameter int unsigned NIB_W = TRC_NIB_W,
    parameter int unsigned NIBS  = TRC_NIBS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   br_valid,
    input  logic [NIB_W*NIBS-1:0]  br_addr,
    output logic                   br_ready,
    output logic                   trc_clk,
    output logic                   trc_sync,
    output logic [NIB_W-1:0]       trc_data
);
    localparam int unsigned ADDR_W = NIB_W * NIBS;
    localparam int unsigned IDX_W  = $clog2(NIBS);

    logic                        tick;
    tx_state_t                   st;
    logic [NIBS-1:0][NIB_W-1:0]  cur;
    logic [IDX_W-1:0]            idx, last_idx, nxt_idx, new_last;
    logic                        sync_q;
    logic [NIB_W-1:0]            data_q;
    logic [ADDR_W-1:0]           ref_q, eff_ref;
    logic                        ref_ok, eff_ok;
    logic                        last_now, accept, finish;
    size_code_t                  code;
    hdr_t                        hdr;

    bts_clkdiv u_div (
        .clk   (clk),
        .rst   (rst),
        .phase (trc_clk),
        .tick  (tick)
    );

    assign last_now = (st == ST_BODY) && (idx == last_idx);
    assign br_ready = tick && ((st == ST_IDLE) || last_now);
    assign accept   = br_valid && br_ready;
    assign finish   = tick && last_now;

    // A packet completing on this edge is the reference for a new header.
    assign eff_ref  = last_now ? ADDR_W'(cur) : ref_q;
    assign eff_ok   = last_now | ref_ok;

    bts_len_enc #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_enc (
        .addr     (br_addr),
        .ref_addr (eff_ref),
        .ref_ok   (eff_ok),
        .code     (code)
    );

    bts_ref_reg #(.ADDR_W(ADDR_W)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .load   (finish),
        .din    (ADDR_W'(cur)),
        .ref_q  (ref_q),
        .ref_ok (ref_ok)
    );

    assign hdr.tag  = HDR_TAG;
    assign hdr.code = code;
    assign nxt_idx  = idx + 1'b1;
    assign new_last = IDX_W'(last_index(code, NIBS));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sync_q   <= 1'b1;
            data_q   <= IDLE_PAT;
            cur      <= '0;
            idx      <= '0;
            last_idx <= '0;
        end else if (tick) begin
            if (accept) begin
                st       <= ST_HEAD;
                sync_q   <= 1'b1;
                data_q   <= NIB_W'(hdr);
                cur      <= br_addr;
                idx      <= '0;
                last_idx <= new_last;
            end else begin
                case (st)
                    ST_HEAD: begin
                        st     <= ST_BODY;
                        sync_q <= 1'b0;
                        data_q <= cur[0];
                        idx    <= '0;
                    end
                    ST_BODY: begin
                        if (idx == last_idx) begin
                            st     <= ST_IDLE;
                            sync_q <= 1'b1;
                            data_q <= IDLE_PAT;
                        end else begin
                            idx    <= nxt_idx;
                            data_q <= cur[nxt_idx];
                        end
                    end
                    default: begin
                        sync_q <= 1'b1;
                        data_q <= IDLE_PAT;
                    end
                endcase
            end
        end
    end

    assign trc_sync = sync_q;
    assign trc_data = data_q;
endmodule

// File: rtl/bts_checker.sv
module bts_checker (
    input logic       clk,
    input logic       rst,
    input logic       br_valid,
    input logic       br_ready,
    input logic       trc_clk,
    input logic       trc_sync,
    input logic [3:0] trc_data
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic is_hdr;
    assign is_hdr = trc_sync && (trc_data[3:2] == 2'b10);

    // R1
    trc_clk_toggle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        trc_clk != $past(trc_clk));

    // R1
    port_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !trc_clk |=> ($stable(trc_sync) && $stable(trc_data)));

    // R2
    idle_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_sync && !is_hdr) |-> (trc_data == 4'b0011));

    // R3
    hdr_then_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (trc_clk && is_hdr) |=> !trc_sync);

    // R8
    ready_phase_chk: assert property (@(posedge clk) disable iff (rst)
        br_ready |-> trc_clk);

    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        is_hdr |-> !br_ready);

    // R9
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
        (br_ready && !trc_sync) |=> trc_sync);

    // R9
    b2b_header_chk: assert property (@(posedge clk) disable iff (rst)
        (br_ready && br_valid) |=> is_hdr);
endmodule

bind branch_trace_serializer bts_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .br_valid (br_valid),
    .br_ready (br_ready),
    .trc_clk  (trc_clk),
    .trc_sync (trc_sync),
    .trc_data (trc_data)
);

// File: tb/branch_trace_serializer_tb.sv
module branch_trace_serializer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic [31:0] br_addr;
    logic        br_ready;
    logic        trc_clk;
    logic        trc_sync;
    logic [3:0]  trc_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    branch_trace_serializer u_dut (
        .clk      (clk),
        .rst      (rst),
        .br_valid (br_valid),
        .br_addr  (br_addr),
        .br_ready (br_ready),
        .trc_clk  (trc_clk),
        .trc_sync (trc_sync),
        .trc_data (trc_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_code(input logic [31:0] a, input logic [31:0] r, input bit rv);
        if (!rv)                  return 2'b11;
        if (a[31:4]  == r[31:4])  return 2'b00;
        if (a[31:8]  == r[31:8])  return 2'b01;
        if (a[31:16] == r[31:16]) return 2'b10;
        return 2'b11;
    endfunction

    // ---------------- stream monitor ----------------
    logic [31:0] exp_q[$];
    logic [31:0] m_ref   = '0;
    bit          m_ref_v = 1'b0;
    int          m_mode  = 0;     // 0 idle, 2 packet body
    int          m_cnt   = 0;
    int          m_tot   = 0;
    logic [31:0] m_cur   = '0;
    bit          p_ok    = 1'b0;
    logic        p_clk, p_sync;
    logic [3:0]  p_data;

    always @(negedge clk) begin
        #1;
        if (rst) begin
            m_mode = 0; m_ref_v = 1'b0; p_ok = 1'b0;
        end else begin
            if (p_ok) begin
                chk(trc_clk != p_clk, "R1 toggle", {31'd0, trc_clk}, {31'd0, ~p_clk});
                if (trc_clk)
                    chk(trc_sync == p_sync && trc_data == p_data, "R1 hold",
                        {27'd0, trc_sync, trc_data}, {27'd0, p_sync, p_data});
            end
            if (trc_clk) begin
                // R8: ready only while idle or on the final nibble
                chk(br_ready == ((m_mode == 0) || (m_cnt == m_tot)), "R8 ready",
                    {31'd0, br_ready}, {31'd0, (m_mode == 0) || (m_cnt == m_tot)});
            end else begin
                if (m_mode == 2 && m_cnt < m_tot) begin
                    chk(!trc_sync, "R5 sync low", {31'd0, trc_sync}, 32'd0);
                    chk(trc_data == m_cur[m_cnt*4 +: 4], "R6 nibble order",
                        {28'd0, trc_data}, {28'd0, m_cur[m_cnt*4 +: 4]});
                    m_cnt++;
                    if (m_cnt == m_tot) begin m_ref = m_cur; m_ref_v = 1'b1; end
                end else if (trc_sync && trc_data == 4'b0011) begin
                    m_mode = 0;
                end else if (trc_sync && trc_data[3:2] == 2'b10) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected header", {28'd0, trc_data}, 32'h3);
                    end else begin
                        logic [1:0] ec;
                        m_cur = exp_q.pop_front();
                        ec = exp_code(m_cur, m_ref, m_ref_v);
                        // R3 R4 R7 R9: header code vs bench reference
                        chk(trc_data == {2'b10, ec}, "R4 header code",
                            {28'd0, trc_data}, {28'd0, 2'b10, ec});
                        m_mode = 2; m_cnt = 0; m_tot = 1 << ec;
                        if (ec == 2'b11) m_tot = 8;
                    end
                end else begin
                    chk(1'b0, "R2 bad symbol", {27'd0, trc_sync, trc_data}, 32'h13);
                end
            end
            p_ok = 1'b1; p_clk = trc_clk; p_sync = trc_sync; p_data = trc_data;
        end
    end

    // ---------------- driver ----------------
    task automatic send(input logic [31:0] a, input int gap);
        repeat (gap) @(negedge clk);
        br_valid = 1'b1;
        br_addr  = a;
        while (!br_ready) @(negedge clk);
        exp_q.push_back(a);
        @(negedge clk);
        br_valid = 1'b0;
        br_addr  = $urandom;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || m_mode != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [31:0] prev;
        void'($urandom(32'd2718));
        rst = 1'b1; br_valid = 1'b0; br_addr = '0;
        repeat (3) @(negedge clk);
        chk(trc_sync == 1'b1 && trc_data == 4'b0011, "R2 reset idle",
            {27'd0, trc_sync, trc_data}, 32'h13);
        chk(trc_clk == 1'b0, "R1 reset phase", {31'd0, trc_clk}, 32'd0);
        chk(br_ready == 1'b0, "R8 reset ready", {31'd0, br_ready}, 32'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(trc_sync == 1'b1 && trc_data == 4'b0011, "R2 idle no branch",
            {27'd0, trc_sync, trc_data}, 32'h13);

        // R7: first after reset is full length even for address 0
        send(32'h0000_0000, 0); drain();
        send(32'h0000_0000, 0); drain();      // R4 code 00
        send(32'h0000_0010, 0); drain();      // R4 code 01
        send(32'h0000_1010, 0); drain();      // R4 code 10
        send(32'h1000_1010, 0); drain();      // R4 code 11
        send(32'h1000_101F, 0); drain();      // R4 code 00, R6 single nibble
        // R9: back-to-back, each header compared with the just-finished one
        send(32'hABCD_1234, 0);
        send(32'hABCD_1235, 0);
        send(32'hABCD_12F5, 0);
        send(32'hABCD_F2F5, 0);
        send(32'h5BCD_F2F5, 0);
        drain();

        prev = 32'h5BCD_F2F5;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            int kind;
            kind = $urandom_range(0, 3);
            case (kind)
                0: a = {prev[31:4],  4'($urandom)};
                1: a = {prev[31:8],  8'($urandom)};
                2: a = {prev[31:16], 16'($urandom)};
                default: a = $urandom;
            endcase
            send(a, $urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 12));
            prev = a;
        end
        drain();

        // R10: reset in the middle of a full packet
        send(32'h4444_4444, 0); drain();
        send(32'hC444_4444, 0);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(trc_sync == 1'b1 && trc_data == 4'b0011, "R10 reset abort idle",
            {27'd0, trc_sync, trc_data}, 32'h13);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge clk);
        // R7 R10: reference invalidated, same address needs code 11
        send(32'h4444_4444, 0); drain();
        send(32'h4444_4440, 0); drain();

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule